// File: doc/BRIEF.md
# Interrupt Request Priority Arbiter

This block sits beside the instruction sequencer of a 16-bit real-mode processor core. At each instruction boundary it looks at every interrupt condition that could be pending and picks one. The candidates are execution faults, single-step tracing, the non-maskable request, coprocessor operand overrun, the maskable external request, and the software interrupt instructions. It then raises a take strobe with the 8-bit type number of the chosen interrupt. It also gives a flag that tells the entry sequencer whether the saved return address must point back at the faulting instruction or forward to the next one.

For a maskable external request, the block first runs an acknowledge handshake. The device returns its own type byte, and that byte becomes the type number. The take strobe and type stay steady until the entry sequencer reports that it is busy. Instruction boundaries that arrive in the meantime are ignored. The stack pushes, the vector fetch and protected-mode checks are not part of this block.

Top module: `irq_arbiter`

## Requirements
- R1: Conditions are judged only in a cycle where `boundary_i` is high. Without a boundary, `take_o` and `inta_o` stay low whatever the requests are.
- R2: When several conditions are present at one boundary, the winner follows this order: divide fault, undefined opcode, single-step, NMI, coprocessor overrun, maskable request, then the software group (INT n, breakpoint, overflow trap, range check). A lower entry loses even when a higher entry is present in the same cycle.
- R3: With `int_en_i` low, `intr_i` produces neither an acknowledge nor a take.
- R4: NMI cannot be masked and yields type 2. A rising edge of `nmi_i` is remembered until it is serviced, and a level held high is serviced only once.
- R5: With `trap_flag_i` high, a boundary yields type 1 unless an execution fault wins.
- R6: The overflow-trap instruction yields type 4 only when `ovf_flag_i` is 1. Otherwise nothing is taken.
- R7: The range check compares `bound_val_i` with `bound_lo_i` and `bound_hi_i` as 16-bit two's-complement values. It yields type 5 only when the value is strictly below the low bound or strictly above the high bound.
- R8: INT n yields `sw_type_i`, the breakpoint yields 3, a divide fault yields 0, an undefined opcode yields 6, and coprocessor overrun yields 9.
- R9: While `take_o` is high, `restart_o` is 1 exactly when `type_o` is one of 0, 5, 6, 7, 8, 10, 11, 12 or 13. It is 0 for every other type and whenever `take_o` is low.
- R10: When the maskable request wins, `inta_o` is high for exactly one cycle after the boundary edge. `ext_type_i` is captured at the next edge, and `take_o` rises in that same cycle with the captured byte.
- R11: `take_o` rises in the cycle after the deciding edge. It then holds, with a stable `type_o`, until `seq_busy_i` is seen high. Boundaries during that time are ignored.
- R12: After reset, `take_o`, `inta_o`, `type_o` and `restart_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Current instruction has completed |
| div_fault_i | input | 1 | Divide overflow or divide by zero |
| bad_opcode_i | input | 1 | Undefined opcode met |
| trap_flag_i | input | 1 | Single-step flag value |
| int_en_i | input | 1 | Maskable interrupt enable flag value |
| nmi_i | input | 1 | Non-maskable request line |
| cop_overrun_i | input | 1 | Coprocessor operand overrun |
| intr_i | input | 1 | Maskable external request |
| inta_o | output | 1 | Acknowledge to external device |
| ext_type_i | input | 8 | Type byte returned by the device |
| sw_int_i | input | 1 | INT n instruction executed |
| sw_type_i | input | 8 | Operand n of INT n |
| sw_brk_i | input | 1 | One-byte breakpoint instruction executed |
| sw_into_i | input | 1 | Overflow-trap instruction executed |
| ovf_flag_i | input | 1 | Overflow flag value |
| bound_i | input | 1 | Range-check instruction executed |
| bound_val_i | input | 16 | Register value being checked |
| bound_lo_i | input | 16 | Low bound word |
| bound_hi_i | input | 16 | High bound word |
| seq_busy_i | input | 1 | Entry sequencer has accepted the request |
| take_o | output | 1 | Interrupt to be entered |
| type_o | output | 8 | Type number of the chosen interrupt |
| restart_o | output | 1 | Return address must point at the faulting instruction |

## Verification
A wrong selection in the priority logic shows on `type_o` in the cycle after the deciding boundary edge. That cycle is also when `take_o` first rises, so each ordering case can be read one cycle after its boundary. A stuck NMI pending bit shows up at a later, otherwise empty boundary, either as a type 2 that should not be there or as a missing one. A handshake state that is off by one cycle shows as `inta_o` lasting two cycles, or as a `type_o` that is not the byte presented during the acknowledge cycle. A take state that leaves too early drops `take_o`, or changes `type_o`, before `seq_busy_i` has been raised.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

   // Number of request sources and their priority slots (0 = highest).
   localparam int unsigned NSRC    = 10;
   localparam int unsigned SRC_W   = $clog2(NSRC);
   localparam int unsigned P_DIV   = 0;
   localparam int unsigned P_OPC   = 1;
   localparam int unsigned P_TRAP  = 2;
   localparam int unsigned P_NMI   = 3;
   localparam int unsigned P_COP   = 4;
   localparam int unsigned P_INTR  = 5;
   localparam int unsigned P_SWN   = 6;
   localparam int unsigned P_BRK   = 7;
   localparam int unsigned P_OVF   = 8;
   localparam int unsigned P_BND   = 9;

   // Fixed type numbers.
   localparam int unsigned T_DIV  = 0;
   localparam int unsigned T_TRAP = 1;
   localparam int unsigned T_NMI  = 2;
   localparam int unsigned T_BRK  = 3;
   localparam int unsigned T_OVF  = 4;
   localparam int unsigned T_BND  = 5;
   localparam int unsigned T_OPC  = 6;
   localparam int unsigned T_COP  = 9;

   // Types whose return address points back at the faulting instruction.
   localparam logic [15:0] RESTART_SET = 16'h3DE1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_HOLD = 2'd2
   } arb_state_e;

   function automatic logic restart_for(input logic [31:0] t);
      return (t < 32'd16) && RESTART_SET[t[3:0]];
   endfunction

endpackage

// File: rtl/irq_bound_cmp.sv
`timescale 1ns/1ps
module irq_bound_cmp #(
   parameter int unsigned DATA_W     = 16,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   output logic              outside_o
);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("irq_bound_cmp: DATA_W must be at least 2");
      end

      if (SIGNED_CMP) begin : g_signed
         logic below, above;
         assign below = $signed(val_i) < $signed(lo_i);
         assign above = $signed(val_i) > $signed(hi_i);
         assign outside_o = below | above;
      end else begin : g_unsigned
         logic below, above;
         assign below = val_i < lo_i;
         assign above = val_i > hi_i;
         assign outside_o = below | above;
      end
   endgenerate

endmodule

// File: rtl/irq_nmi_latch.sv
`timescale 1ns/1ps
module irq_nmi_latch #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic clear_i,
   output logic pending_o
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         logic pend_q;
         logic rise;

         assign rise = nmi_i & ~prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               pend_q <= 1'b0;
            end else begin
               prev_q <= nmi_i;
               if (rise)
                  pend_q <= 1'b1;
               else if (clear_i)
                  pend_q <= 1'b0;
            end
         end

         assign pending_o = pend_q;
      end else begin : g_level
         logic unused_clr;
         assign unused_clr = clear_i ^ clk ^ rst_n;
         assign pending_o  = nmi_i;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
   import irq_arb_pkg::*;
#(
   parameter int unsigned TYPE_W = 8
) (
   input  logic [NSRC-1:0]             req_i,
   input  logic [NSRC-1:0][TYPE_W-1:0] type_tab_i,
   output logic                        win_valid_o,
   output logic [SRC_W-1:0]            win_idx_o,
   output logic [TYPE_W-1:0]           win_type_o
);

   // Scan from lowest to highest priority so the last hit is the winner.
   always_comb begin
      win_valid_o = 1'b0;
      win_idx_o   = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            win_valid_o = 1'b1;
            win_idx_o   = SRC_W'(i);
         end
      end
   end

   always_comb begin
      win_type_o = '0;
      for (int j = 0; j < NSRC; j++) begin
         if (win_idx_o == SRC_W'(j))
            win_type_o = type_tab_i[j];
      end
   end

endmodule

// File: rtl/irq_ack_fsm.sv
`timescale 1ns/1ps
module irq_ack_fsm
   import irq_arb_pkg::*;
#(
   parameter int unsigned TYPE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              win_valid_i,
   input  logic              win_ext_i,
   input  logic [TYPE_W-1:0] win_type_i,
   input  logic [TYPE_W-1:0] ext_type_i,
   input  logic              seq_busy_i,
   output logic              grant_o,
   output logic              inta_o,
   output logic              take_o,
   output logic [TYPE_W-1:0] type_o
);

   arb_state_e        state_q;
   logic [TYPE_W-1:0] type_q;

   assign grant_o = (state_q == ST_IDLE) && boundary_i && win_valid_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         type_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (grant_o) begin
                  if (win_ext_i) begin
                     state_q <= ST_ACK;
                  end else begin
                     state_q <= ST_HOLD;
                     type_q  <= win_type_i;
                  end
               end
            end
            ST_ACK: begin
               type_q  <= ext_type_i;
               state_q <= ST_HOLD;
            end
            ST_HOLD: begin
               if (seq_busy_i)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign inta_o = (state_q == ST_ACK);
   assign take_o = (state_q == ST_HOLD);
   assign type_o = type_q;

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned TYPE_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter bit          SIGNED_BND  = 1'b1,
   parameter bit          NMI_EDGE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              div_fault_i,
   input  logic              bad_opcode_i,
   input  logic              trap_flag_i,
   input  logic              int_en_i,
   input  logic              nmi_i,
   input  logic              cop_overrun_i,
   input  logic              intr_i,
   output logic              inta_o,
   input  logic [TYPE_W-1:0] ext_type_i,
   input  logic              sw_int_i,
   input  logic [TYPE_W-1:0] sw_type_i,
   input  logic              sw_brk_i,
   input  logic              sw_into_i,
   input  logic              ovf_flag_i,
   input  logic              bound_i,
   input  logic [DATA_W-1:0] bound_val_i,
   input  logic [DATA_W-1:0] bound_lo_i,
   input  logic [DATA_W-1:0] bound_hi_i,
   input  logic              seq_busy_i,
   output logic              take_o,
   output logic [TYPE_W-1:0] type_o,
   output logic              restart_o
);

   generate
      if (TYPE_W < 4 || TYPE_W > 16) begin : g_bad_type_w
         $error("irq_arbiter: TYPE_W must be within 4..16");
      end
   endgenerate

   logic                        nmi_pend;
   logic                        nmi_clr;
   logic                        bnd_outside;
   logic [NSRC-1:0]             req;
   logic [NSRC-1:0][TYPE_W-1:0] type_tab;
   logic                        win_valid;
   logic [SRC_W-1:0]            win_idx;
   logic [TYPE_W-1:0]           win_type;
   logic                        grant;

   irq_nmi_latch #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_i     (nmi_i),
      .clear_i   (nmi_clr),
      .pending_o (nmi_pend)
   );

   irq_bound_cmp #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_BND)) u_bnd (
      .val_i     (bound_val_i),
      .lo_i      (bound_lo_i),
      .hi_i      (bound_hi_i),
      .outside_o (bnd_outside)
   );

   always_comb begin
      req           = '0;
      req[P_DIV]    = div_fault_i;
      req[P_OPC]    = bad_opcode_i;
      req[P_TRAP]   = trap_flag_i;
      req[P_NMI]    = nmi_pend;
      req[P_COP]    = cop_overrun_i;
      req[P_INTR]   = intr_i & int_en_i;
      req[P_SWN]    = sw_int_i;
      req[P_BRK]    = sw_brk_i;
      req[P_OVF]    = sw_into_i & ovf_flag_i;
      req[P_BND]    = bound_i & bnd_outside;
   end

   always_comb begin
      type_tab         = '0;
      type_tab[P_DIV]  = TYPE_W'(T_DIV);
      type_tab[P_OPC]  = TYPE_W'(T_OPC);
      type_tab[P_TRAP] = TYPE_W'(T_TRAP);
      type_tab[P_NMI]  = TYPE_W'(T_NMI);
      type_tab[P_COP]  = TYPE_W'(T_COP);
      type_tab[P_INTR] = ext_type_i;
      type_tab[P_SWN]  = sw_type_i;
      type_tab[P_BRK]  = TYPE_W'(T_BRK);
      type_tab[P_OVF]  = TYPE_W'(T_OVF);
      type_tab[P_BND]  = TYPE_W'(T_BND);
   end

   irq_prio_sel #(.TYPE_W(TYPE_W)) u_sel (
      .req_i       (req),
      .type_tab_i  (type_tab),
      .win_valid_o (win_valid),
      .win_idx_o   (win_idx),
      .win_type_o  (win_type)
   );

   irq_ack_fsm #(.TYPE_W(TYPE_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary_i),
      .win_valid_i (win_valid),
      .win_ext_i   (win_idx == SRC_W'(P_INTR)),
      .win_type_i  (win_type),
      .ext_type_i  (ext_type_i),
      .seq_busy_i  (seq_busy_i),
      .grant_o     (grant),
      .inta_o      (inta_o),
      .take_o      (take_o),
      .type_o      (type_o)
   );

   assign nmi_clr   = grant && (win_idx == SRC_W'(P_NMI));
   assign restart_o = take_o && restart_for(32'(type_o));

endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
   parameter int unsigned TYPE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boundary_i,
   input logic              int_en_i,
   input logic              seq_busy_i,
   input logic              take_o,
   input logic              inta_o,
   input logic [TYPE_W-1:0] type_o,
   input logic              restart_o
);

   a_r11_take_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !seq_busy_i) |=> take_o);

   a_r11_type_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !seq_busy_i) |=> $stable(type_o));

   a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      inta_o |=> !inta_o);

   a_r10_ack_then_take: assert property (@(posedge clk) disable iff (!rst_n)
      inta_o |=> take_o);

   a_r3_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inta_o) |-> $past(int_en_i));

   a_r1_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(take_o) || $rose(inta_o)) |-> ($past(boundary_i) || $past(inta_o)));

   a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> !restart_o);

   a_r9_trap_continue: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && type_o == TYPE_W'(1)) |-> !restart_o);

endmodule

bind irq_arbiter irq_arbiter_chk #(.TYPE_W(TYPE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boundary_i (boundary_i),
   .int_en_i   (int_en_i),
   .seq_busy_i (seq_busy_i),
   .take_o     (take_o),
   .inta_o     (inta_o),
   .type_o     (type_o),
   .restart_o  (restart_o)
);

// File: tb/irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary_i = 0, div_fault_i = 0, bad_opcode_i = 0, trap_flag_i = 0;
   logic        int_en_i = 0, nmi_i = 0, cop_overrun_i = 0, intr_i = 0;
   logic [7:0]  ext_type_i = 0;
   logic        sw_int_i = 0, sw_brk_i = 0, sw_into_i = 0, ovf_flag_i = 0, bound_i = 0;
   logic [7:0]  sw_type_i = 0;
   logic [15:0] bound_val_i = 0, bound_lo_i = 0, bound_hi_i = 0;
   logic        seq_busy_i = 0;
   logic        inta_o, take_o, restart_o;
   logic [7:0]  type_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
      .div_fault_i(div_fault_i), .bad_opcode_i(bad_opcode_i),
      .trap_flag_i(trap_flag_i), .int_en_i(int_en_i), .nmi_i(nmi_i),
      .cop_overrun_i(cop_overrun_i), .intr_i(intr_i), .inta_o(inta_o),
      .ext_type_i(ext_type_i), .sw_int_i(sw_int_i), .sw_type_i(sw_type_i),
      .sw_brk_i(sw_brk_i), .sw_into_i(sw_into_i), .ovf_flag_i(ovf_flag_i),
      .bound_i(bound_i), .bound_val_i(bound_val_i), .bound_lo_i(bound_lo_i),
      .bound_hi_i(bound_hi_i), .seq_busy_i(seq_busy_i), .take_o(take_o),
      .type_o(type_o), .restart_o(restart_o)
   );

   typedef struct packed {
      logic        div, opc, trap, ie, nmi, cop, intr;
      logic [7:0]  ext;
      logic        swn;
      logic [7:0]  swt;
      logic        brk, into, ovf, bnd;
      logic [15:0] val, lo, hi;
      logic        e_take, e_ack;
      logic [7:0]  e_type;
      logic        e_rst;
   } vec_t;

   localparam int NV = 26;
   // Fields: div opc trap ie nmi cop intr ext swn swt brk into ovf bnd val lo hi | take ack type restart
   localparam vec_t VECS [NV] = '{
      '{1,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd0,1},  // R8 divide
      '{0,1,0,0,0,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd6,1},  // R8 opcode
      '{0,0,1,0,0,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd1,0},  // R5 trap
      '{0,0,0,0,1,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd2,0},  // R4 nmi with IF=0
      '{0,0,0,0,0,1,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd9,0},  // R8 overrun
      '{0,0,0,1,0,0,1,8'h48,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,1,8'h48,0}, // R10 intr
      '{0,0,0,0,0,0,1,8'h48,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 0,0,8'd0,0},  // R3 masked
      '{0,0,0,0,0,0,0,8'h00,1,8'h80,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'h80,0}, // R8 INT n
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,1,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd3,0},  // R8 breakpoint
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,1,0,0,16'h0000,16'h0000,16'h0000, 0,0,8'd0,0},  // R6 OF=0
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,1,1,0,16'h0000,16'h0000,16'h0000, 1,0,8'd4,0},  // R6 OF=1
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'd10,16'd10,16'd20,       0,0,8'd0,0},  // R7 at low
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'd20,16'd10,16'd20,       0,0,8'd0,0},  // R7 at high
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'd21,16'd10,16'd20,       1,0,8'd5,1},  // R7 above
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'd9,16'd10,16'd20,        1,0,8'd5,1},  // R7 below
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'hFFFA,16'hFFFB,16'h000A, 1,0,8'd5,1},  // R7 -6 < -5
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'hFFFB,16'hFFFB,16'h000A, 0,0,8'd0,0},  // R7 -5 inside
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,1,16'h8000,16'h0000,16'h7FFF, 1,0,8'd5,1},  // R7 signed
      '{1,0,1,1,1,0,1,8'h48,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd0,1},  // R2 div wins
      '{0,0,0,0,0,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd2,0},  // R4 nmi kept
      '{0,0,1,0,1,1,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd1,0},  // R2 trap wins
      '{0,0,0,1,0,1,1,8'h48,1,8'h21,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd2,0},  // R2 nmi wins
      '{0,0,0,1,0,1,1,8'h48,1,8'h21,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd9,0},  // R2 overrun wins
      '{0,0,0,1,0,0,1,8'h0D,1,8'h21,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,1,8'h0D,1}, // R2 intr wins, R9
      '{0,0,0,0,0,0,0,8'h00,1,8'h05,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd5,1},  // R9 INT 5
      '{1,1,0,0,0,0,0,8'h00,0,8'h00,0,0,0,0,16'h0000,16'h0000,16'h0000, 1,0,8'd0,1}   // R2 div over opcode
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      boundary_i = 0; div_fault_i = 0; bad_opcode_i = 0; trap_flag_i = 0;
      int_en_i = 0; nmi_i = 0; cop_overrun_i = 0; intr_i = 0; ext_type_i = 0;
      sw_int_i = 0; sw_type_i = 0; sw_brk_i = 0; sw_into_i = 0; ovf_flag_i = 0;
      bound_i = 0; bound_val_i = 0; bound_lo_i = 0; bound_hi_i = 0; seq_busy_i = 0;
   endtask

   task automatic release_take();
      @(negedge clk); seq_busy_i = 1;
      @(negedge clk); seq_busy_i = 0;
      chk("R11 take drops after busy", take_o, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 take", take_o, 0);
      chk("R12 inta", inta_o, 0);
      chk("R12 type", type_o, 0);
      chk("R12 restart", restart_o, 0);
      rst_n = 1;
      @(negedge clk);

      foreach (VECS[k]) begin
         vec_t v;
         v = VECS[k];
         div_fault_i = v.div; bad_opcode_i = v.opc; trap_flag_i = v.trap;
         int_en_i = v.ie; nmi_i = v.nmi; cop_overrun_i = v.cop; intr_i = v.intr;
         sw_int_i = v.swn; sw_type_i = v.swt; sw_brk_i = v.brk; sw_into_i = v.into;
         ovf_flag_i = v.ovf; bound_i = v.bnd; bound_val_i = v.val;
         bound_lo_i = v.lo; bound_hi_i = v.hi;
         @(negedge clk);
         boundary_i = 1;
         @(negedge clk);
         idle_inputs();
         if (v.e_ack) begin
            chk($sformatf("R10 vec%0d inta", k), inta_o, 1);
            chk($sformatf("R10 vec%0d no take yet", k), take_o, 0);
            ext_type_i = v.ext;
            @(negedge clk);
            ext_type_i = 8'hEE;
            chk($sformatf("R10 vec%0d inta single", k), inta_o, 0);
         end
         chk($sformatf("R2 vec%0d take", k), take_o, v.e_take);
         chk($sformatf("R3 vec%0d no ack", k), inta_o, 0);
         if (v.e_take) begin
            chk($sformatf("R8 vec%0d type", k), type_o, v.e_type);
            chk($sformatf("R9 vec%0d restart", k), restart_o, v.e_rst);
            release_take();
         end
         @(negedge clk);
      end

      // R1: requests without a boundary do nothing
      div_fault_i = 1; trap_flag_i = 1; sw_brk_i = 1;
      repeat (3) @(negedge clk);
      chk("R1 no take without boundary", take_o, 0);
      chk("R1 no ack without boundary", inta_o, 0);
      idle_inputs();
      @(negedge clk);

      // R11: hold while not busy; later boundaries ignored
      div_fault_i = 1; boundary_i = 1;
      @(negedge clk);
      idle_inputs();
      trap_flag_i = 1; boundary_i = 1;
      repeat (4) begin
         @(negedge clk);
         chk("R11 take held", take_o, 1);
         chk("R11 type stable", type_o, 0);
      end
      idle_inputs();
      release_take();
      @(negedge clk);
      chk("R11 ignored boundary not kept", take_o, 0);

      // R4: a level held high is serviced once only
      nmi_i = 1;
      @(negedge clk);
      boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk("R4 nmi type", type_o, 2);
      chk("R4 nmi take", take_o, 1);
      release_take();
      boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk("R4 held level not serviced twice", take_o, 0);
      idle_inputs();
      @(negedge clk);

      // R5: trap at consecutive boundaries
      trap_flag_i = 1; boundary_i = 1;
      @(negedge clk);
      boundary_i = 0;
      chk("R5 trap first", type_o, 1);
      release_take();
      boundary_i = 1;
      @(negedge clk);
      idle_inputs();
      chk("R5 trap again", take_o, 1);
      chk("R5 trap type again", type_o, 1);
      release_take();

      finish_run();
   end

endmodule